// File: doc/BRIEF.md
# Wide Fetch Instruction Queue

This block decouples a wide instruction fetch stage from a narrower decode stage. Each cycle the fetch side presents one whole cache line of sixteen 32-bit words for the current fetch address. The block takes a group of instructions from that line, starting at the fetch address. The group holds at most twelve words and ends at the end of the line. The block stores the group in a 48-entry circular queue. The block also owns the fetch address register and moves it forward by the size of each accepted group.

Decode sees up to six of the oldest queued instructions each cycle, packed from slot 0 upward, each with its address. Decode reports how many of them it consumed. When the queue cannot hold one more maximum-size group, the fetch-enable output drops so that the fetch side can be clock gated. A late redirect from the slower predictor level empties the queue in one cycle and loads the corrected fetch address. The rest of the pipeline is not affected.

Top module: `fiq_top`

## Requirements
- R1: While reset is asserted and directly after it, the queue is empty: `out_valid` is 0, `fetch_pc` equals `RESET_PC` (default 0), `fetch_en` is 1 and `q_full` is 0.
- R2: Word k of the line sits at `line_data[32k+31:32k]`. An accepted group starts at word index `fetch_pc[5:2]` and holds min(12, 16 − `fetch_pc[5:2]`) words. The words keep their order, and each word is tagged with the address `fetch_pc + 4·i`.
- R3: After an accepted group, `fetch_pc` is larger by four times the group size on the next cycle.
- R4: A line is taken only when `line_valid` and `fetch_en` are both 1 and `redirect_valid` is 0. In any other cycle the line is ignored: `fetch_pc` and the queue contents stay unchanged.
- R5: `fetch_en` is 1 exactly when at least 12 of the 48 entries are free.
- R6: `q_full` is 1 exactly when all 48 entries are occupied.
- R7: Output slot j shows the (j+1)-th oldest entry. `out_valid` has its low min(6, occupancy) bits set and no other bits set.
- R8: In a cycle without redirect, decode consumes min(`dec_take`, number of valid slots) of the oldest entries. The same cycle may also take in a new group.
- R9: `redirect_valid` overrides enqueue and dequeue in the same cycle. On the next cycle the queue is empty and `fetch_pc` equals `redirect_pc`, which must be word aligned.
- R10: Queued instructions stay in program order. Each valid slot above 0 holds the address of the slot below it plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_valid | input | 1 | Line data for the line that holds `fetch_pc` is present |
| line_data | input | 512 | Sixteen 32-bit words, word k at bits 32k+31:32k |
| redirect_valid | input | 1 | Late predictor override: flush the queue and restart fetch |
| redirect_pc | input | 32 | Corrected fetch address, word aligned |
| dec_take | input | 3 | Number of output slots consumed by decode this cycle |
| fetch_pc | output | 32 | Current fetch address |
| fetch_en | output | 1 | Fetch may proceed (at least one full group fits) |
| q_full | output | 1 | All queue entries occupied |
| out_valid | output | 6 | Per-slot valid bits, contiguous from slot 0 |
| out_insn | output | 192 | Slot j instruction at bits 32j+31:32j |
| out_pc | output | 192 | Slot j address at bits 32j+31:32j |

## Verification
Every output is a combinational function of registers only. An input pattern applied in one cycle therefore becomes visible at the outputs right after the next rising edge. This covers the fetch address step, the new queue contents, the drained slots, the gated `fetch_en` and the emptied queue after a redirect, all exactly one edge later. The bench drives inputs on the falling edge and advances its reference model in the same step. On the following falling edge it compares every output against that model. In this way each expected value is sampled exactly one edge after its cause and half a period away from any transition.

// File: rtl/fiq_pkg.sv
package fiq_pkg;
    localparam int XLEN = 32;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] insn;
    } fiq_entry_t;
endpackage

// File: rtl/fiq_group_calc.sv
module fiq_group_calc
    import fiq_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    parameter int FETCH_W    = 12,
    localparam int OFFW      = $clog2(LINE_WORDS),
    localparam int GW        = $clog2(FETCH_W + 1)
) (
    input  logic [XLEN-1:0]            start_pc,
    input  logic [LINE_WORDS*XLEN-1:0] line_data,
    output logic [GW-1:0]              grp_cnt,
    output fiq_entry_t [FETCH_W-1:0]   grp
);
    logic [OFFW-1:0] off;
    assign off = start_pc[2 +: OFFW];

    // group size is cut at the end of the line
    always_comb begin : c_cnt
        int room;
        room    = LINE_WORDS - int'(off);
        grp_cnt = (room < FETCH_W) ? GW'(room) : GW'(FETCH_W);
    end

    for (genvar k = 0; k < FETCH_W; k++) begin : g_slot
        always_comb begin : c_slot
            int w;
            w            = (int'(off) + k) % LINE_WORDS;
            grp[k].pc    = start_pc + XLEN'(4 * k);
            grp[k].insn  = line_data[w*XLEN +: XLEN];
        end
    end
endmodule

// File: rtl/fiq_storage.sv
module fiq_storage
    import fiq_pkg::*;
#(
    parameter int DEPTH   = 48,
    parameter int FETCH_W = 12,
    parameter int DEC_W   = 6,
    localparam int IW     = $clog2(DEPTH),
    localparam int GW     = $clog2(FETCH_W + 1)
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [IW-1:0]            wr_idx,
    input  logic [GW-1:0]            wr_cnt,
    input  fiq_entry_t [FETCH_W-1:0] wr_data,
    input  logic [IW-1:0]            rd_idx,
    output fiq_entry_t [DEC_W-1:0]   rd_data
);
    fiq_entry_t mem_q [DEPTH];
    fiq_entry_t mem_d [DEPTH];

    function automatic int wrap_idx(input int v);
        return (v >= DEPTH) ? v - DEPTH : v;
    endfunction

    always_comb begin : c_write
        mem_d = mem_q;
        for (int k = 0; k < FETCH_W; k++) begin
            if (wr_en && (k < int'(wr_cnt))) begin
                mem_d[wrap_idx(int'(wr_idx) + k)] = wr_data[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar j = 0; j < DEC_W; j++) begin : g_rd
        assign rd_data[j] = mem_q[wrap_idx(int'(rd_idx) + j)];
    end
endmodule

// File: rtl/fiq_top.sv
module fiq_top
    import fiq_pkg::*;
#(
    parameter int          LINE_WORDS = 16,
    parameter int          FETCH_W    = 12,
    parameter int          DEC_W      = 6,
    parameter int          DEPTH      = 48,
    parameter logic [31:0] RESET_PC   = 32'h0,
    localparam int         DW         = $clog2(DEC_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       line_valid,
    input  logic [LINE_WORDS*XLEN-1:0] line_data,
    input  logic                       redirect_valid,
    input  logic [XLEN-1:0]            redirect_pc,
    input  logic [DW-1:0]              dec_take,
    output logic [XLEN-1:0]            fetch_pc,
    output logic                       fetch_en,
    output logic                       q_full,
    output logic [DEC_W-1:0]           out_valid,
    output logic [DEC_W*XLEN-1:0]      out_insn,
    output logic [DEC_W*XLEN-1:0]      out_pc
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int GW = $clog2(FETCH_W + 1);

    typedef struct packed {
        logic [IW-1:0]   wr_idx;
        logic            wr_wrap;
        logic [IW-1:0]   rd_idx;
        logic            rd_wrap;
        logic [XLEN-1:0] pc;
    } st_t;

    localparam st_t ST_RST = '{wr_idx: '0, wr_wrap: 1'b0, rd_idx: '0, rd_wrap: 1'b0, pc: RESET_PC};

    st_t st_q, st_d;

    logic [GW-1:0]            grp_cnt;
    fiq_entry_t [FETCH_W-1:0] grp;
    fiq_entry_t [DEC_W-1:0]   rd_data;
    logic [CW-1:0]            occ;
    logic [CW-1:0]            avail;
    logic [DW-1:0]            take;
    logic                     accept;

    function automatic logic [IW:0] ptr_adv(input logic wrap, input logic [IW-1:0] idx, input int n);
        int s;
        s = int'(idx) + n;
        if (s >= DEPTH) return {~wrap, IW'(s - DEPTH)};
        return {wrap, IW'(s)};
    endfunction

    fiq_group_calc #(.LINE_WORDS(LINE_WORDS), .FETCH_W(FETCH_W)) u_grp (
        .start_pc  (st_q.pc),
        .line_data (line_data),
        .grp_cnt   (grp_cnt),
        .grp       (grp)
    );

    fiq_storage #(.DEPTH(DEPTH), .FETCH_W(FETCH_W), .DEC_W(DEC_W)) u_mem (
        .clk     (clk),
        .wr_en   (accept),
        .wr_idx  (st_q.wr_idx),
        .wr_cnt  (grp_cnt),
        .wr_data (grp),
        .rd_idx  (st_q.rd_idx),
        .rd_data (rd_data)
    );

    always_comb begin : c_occ
        if (st_q.wr_wrap == st_q.rd_wrap) occ = CW'(int'(st_q.wr_idx) - int'(st_q.rd_idx));
        else                              occ = CW'(DEPTH - int'(st_q.rd_idx) + int'(st_q.wr_idx));
        avail = (int'(occ) < DEC_W) ? occ : CW'(DEC_W);
        take  = (int'(dec_take) < int'(avail)) ? dec_take : DW'(avail);
    end

    assign fetch_en = (DEPTH - int'(occ)) >= FETCH_W;
    assign q_full   = int'(occ) == DEPTH;
    assign accept   = line_valid && fetch_en && !redirect_valid;
    assign fetch_pc = st_q.pc;

    for (genvar j = 0; j < DEC_W; j++) begin : g_out
        assign out_valid[j]            = j < int'(avail);
        assign out_insn[j*XLEN +: XLEN] = rd_data[j].insn;
        assign out_pc[j*XLEN +: XLEN]   = rd_data[j].pc;
    end

    always_comb begin : c_next
        st_d = st_q;
        if (redirect_valid) begin
            st_d.rd_idx  = st_q.wr_idx;
            st_d.rd_wrap = st_q.wr_wrap;
            st_d.pc      = redirect_pc;
        end else begin
            if (accept) begin
                {st_d.wr_wrap, st_d.wr_idx} = ptr_adv(st_q.wr_wrap, st_q.wr_idx, int'(grp_cnt));
                st_d.pc = st_q.pc + XLEN'({grp_cnt, 2'b00});
            end
            {st_d.rd_wrap, st_d.rd_idx} = ptr_adv(st_q.rd_wrap, st_q.rd_idx, int'(take));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH); // R6
    AST_FULL_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !fetch_en); // R5
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (out_valid == '0)); // R9
    AST_FLUSH_PC: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (fetch_pc == $past(redirect_pc))); // R9
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (fetch_pc == $past(st_q.pc + XLEN'({grp_cnt, 2'b00})))); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !redirect_valid) |=> $stable(fetch_pc)); // R4
    AST_OUT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_valid & (out_valid + 1'b1)) == '0)); // R7

    for (genvar j = 1; j < DEC_W; j++) begin : g_ord
        AST_PROG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (out_pc[j*XLEN +: XLEN] == out_pc[(j-1)*XLEN +: XLEN] + 32'd4)); // R10
    end
endmodule

// File: tb/fiq_top_bench.sv
module fiq_top_bench;
    localparam int LW    = 16;
    localparam int FW    = 12;
    localparam int DW    = 6;
    localparam int DEPTH = 48;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n;
    logic             line_valid;
    logic [LW*32-1:0] line_data;
    logic             redirect_valid;
    logic [31:0]      redirect_pc;
    logic [2:0]       dec_take;
    logic [31:0]      fetch_pc;
    logic             fetch_en;
    logic             q_full;
    logic [DW-1:0]    out_valid;
    logic [DW*32-1:0] out_insn;
    logic [DW*32-1:0] out_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit saw_full = 1'b0;

    logic [31:0] m_pc;
    logic [31:0] qpc[$];
    logic [31:0] qin[$];

    fiq_top u_fiq_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .line_valid     (line_valid),
        .line_data      (line_data),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .dec_take       (dec_take),
        .fetch_pc       (fetch_pc),
        .fetch_en       (fetch_en),
        .q_full         (q_full),
        .out_valid      (out_valid),
        .out_insn       (out_insn),
        .out_pc         (out_pc)
    );

    function automatic logic [31:0] insn_of(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h00C0FFEE;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int sz = qpc.size();
        int av = (sz < DW) ? sz : DW;
        chk("R2/R3/R9 fetch_pc", fetch_pc, m_pc);
        chk("R5 fetch_en", 32'(fetch_en), 32'((DEPTH - sz) >= FW));
        chk("R6 q_full", 32'(q_full), 32'(sz == DEPTH));
        for (int j = 0; j < DW; j++) begin
            chk("R7/R9 out_valid", 32'(out_valid[j]), 32'(j < av));
            if (j < av) begin
                chk("R2/R4/R8 out_insn", out_insn[j*32 +: 32], qin[j]);
                chk("R10 out_pc", out_pc[j*32 +: 32], qpc[j]);
            end
        end
    endtask

    task automatic model_step(input bit lv, input int tk, input bit rv, input logic [31:0] rpc);
        int sz = qpc.size();
        bit en = (DEPTH - sz) >= FW;
        int av = (sz < DW) ? sz : DW;
        int t  = (tk < av) ? tk : av;
        int off;
        int n;
        if (rv) begin
            qpc.delete();
            qin.delete();
            m_pc = rpc;
        end else begin
            repeat (t) begin
                void'(qpc.pop_front());
                void'(qin.pop_front());
            end
            if (lv && en) begin
                off = int'(m_pc[5:2]);
                n   = LW - off;
                if (n > FW) n = FW;
                for (int i = 0; i < n; i++) begin
                    qpc.push_back(m_pc + 32'(4 * i));
                    qin.push_back(insn_of(m_pc + 32'(4 * i)));
                end
                m_pc = m_pc + 32'(4 * n);
            end
        end
        if (qpc.size() == DEPTH) saw_full = 1'b1;
    endtask

    task automatic step(input bit lv, input int tk, input bit rv, input logic [31:0] rpc);
        logic [31:0] base;
        @(negedge clk);
        compare_all();
        base = m_pc & 32'hFFFF_FFC0;
        for (int k = 0; k < LW; k++) line_data[k*32 +: 32] = insn_of(base + 32'(4 * k));
        line_valid     = lv;
        dec_take       = 3'(tk);
        redirect_valid = rv;
        redirect_pc    = rpc;
        model_step(lv, tk, rv, rpc);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin : main
        rst_n = 1'b0;
        line_valid = 1'b0;
        line_data = '0;
        redirect_valid = 1'b0;
        redirect_pc = '0;
        dec_take = '0;
        m_pc = 32'h0;
        repeat (3) @(negedge clk);
        chk("R1 reset fetch_pc", fetch_pc, 32'h0);
        chk("R1 reset out_valid", 32'(out_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fetch_en after reset", 32'(fetch_en), 32'h1);
        chk("R1 q_full after reset", 32'(q_full), 32'h0);
        chk("R1 empty after reset", 32'(out_valid), 32'h0);

        // fill to exactly 48 entries through alternating 12- and 4-word groups
        repeat (5) step(1, 0, 0, 32'h0);
        step(0, 6, 0, 32'h0);
        step(0, 2, 0, 32'h0);
        step(1, 0, 0, 32'h0);
        step(0, 4, 0, 32'h0);
        step(1, 0, 0, 32'h0);
        step(1, 0, 0, 32'h0);   // line offered while full: must be ignored
        @(negedge clk);
        chk("R6 queue reached full", 32'(q_full), 32'h1);
        chk("R5 gated while full", 32'(fetch_en), 32'h0);
        chk("R4 ignored line leaves fetch_pc", fetch_pc, 32'h0000_00F0);
        chk("R7 six slots shown when full", 32'(out_valid), 32'h3F);

        repeat (10) step(0, 6, 0, 32'h0);

        // redirects with concurrent fetch and decode, various line offsets
        step(1, 3, 1, 32'h0000_1000);
        step(1, 2, 0, 32'h0);
        step(1, 1, 1, 32'h0000_103C);
        step(1, 0, 0, 32'h0);
        step(1, 6, 1, 32'h0000_2010);
        step(1, 0, 0, 32'h0);
        step(1, 0, 1, 32'h0000_2014);
        repeat (3) step(1, 6, 0, 32'h0);

        repeat (4000) begin
            bit lv = ($urandom % 4) != 0;
            int tk = int'($urandom % 8);
            bit rv = ($urandom % 40) == 0;
            step(lv, tk, rv, $urandom & 32'hFFFF_FFFC);
        end
        @(negedge clk);
        compare_all();
        chk("R6 full state observed", 32'(saw_full), 32'h1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule